// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block captures a clock generator's configuration straps exactly once, on the first clean rising edge of a power-good pin after reset. The straps are a three-bit CPU frequency code, a debug-port enable and a test-select. After that capture the same pin changes role and acts as a live, active-low power-down request.

The captured frequency code is presented together with a reserved flag. The captured debug-port enable decides whether a shared differential clock pair is driven as a serial-reference clock or as a third CPU clock.

When test-select is high at the moment of capture, the block enters test mode. In test mode every later rising edge of power-good captures the straps again. The middle frequency strap then chooses the output behaviour live: either the outputs are tri-stated or they carry a divided reference. The power-good pin is synchronized before use, and reset is asserted asynchronously and released synchronously.

Top module: `pgs_strap_ctl`

## Requirements
- R1: While reset is held and after it is released with no capture yet, the outputs have these values: `freq_code_o` = 3'b101 (100 MHz), `freq_rsvd_o` = 0, `pair_cpu_o` = 0, `test_mode_o` = 0, `tristate_o` = 0, `refdiv_o` = 0, `pdn_req_o` = 0.
- R2: The first synchronized rising edge of `pg_pin_i` after reset loads `fsel_i` into `freq_code_o`. The codes for the CPU clock are: 000=266, 001=133, 010=200, 011=166, 100=333, 101=100 and 110=400 MHz. The new code is visible no later than 3 clock edges after the pin rises.
- R3: The same capture loads `dbg_en_i`. A captured 0 gives `pair_cpu_o` = 0, which routes the shared pair as a serial-reference clock. A captured 1 gives `pair_cpu_o` = 1, which routes it as a third CPU clock.
- R4: Outside test mode, after the first capture, later changes on the straps and later power-good edges leave `freq_code_o`, `freq_rsvd_o`, `pair_cpu_o` and `test_mode_o` unchanged.
- R5: `pdn_req_o` is 0 until the first capture. From then on it equals the inverse of the synchronized `pg_pin_i`.
- R6: If `tsel_i` is 1 at a capture, `test_mode_o` becomes 1. If it is 0, `test_mode_o` is 0.
- R7: In test mode, `fsel_i[1]` = 0 gives `tristate_o` = 1, and `fsel_i[1]` = 1 gives `refdiv_o` = 1. Both follow the pin within 2 cycles. Outside test mode both are 0.
- R8: In test mode, every new synchronized rising edge of `pg_pin_i` captures all straps again, including `tsel_i`.
- R9: Capturing code 3'b111 sets `freq_rsvd_o` = 1 and keeps the previous `freq_code_o` (3'b101 if nothing valid was captured). A later valid capture clears the flag.
- R10: `freq_code_o` never shows 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 3 | Frequency-select straps |
| dbg_en_i | input | 1 | Debug-port enable strap |
| tsel_i | input | 1 | Test-select strap |
| pg_pin_i | input | 1 | Power-good input, later a power-down request (low) |
| freq_code_o | output | 3 | Captured frequency code |
| freq_rsvd_o | output | 1 | Reserved code was captured |
| pair_cpu_o | output | 1 | Shared pair is routed as a CPU clock |
| test_mode_o | output | 1 | Test mode active |
| tristate_o | output | 1 | Tri-state the outputs (test mode) |
| refdiv_o | output | 1 | Drive the divided reference (test mode) |
| pdn_req_o | output | 1 | Power-down request |

## Verification
A rising edge of power-good in test mode does two things in the same cycle: it re-captures the straps and it withdraws the power-down request. Random sequences drive pin lows and highs with test-select often high and straps that sometimes carry the reserved code, so the two effects regularly coincide, with the reserved-code hold also falling in that cycle. After each pin or strap move the bench waits until the synchronizer has settled. It then compares every output against a model that applies the capture rules and the live power-down rule independently.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int FS_W = 3;
  localparam logic [FS_W-1:0] FS_DEFAULT = 3'b101;
  localparam logic [FS_W-1:0] FS_RSVD    = 3'b111;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pgs_strap_latch.sv
module pgs_strap_latch
  import pgs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_s,
  input  logic [FS_W-1:0] fsel,
  input  logic            dbg_en,
  input  logic            tsel,
  output logic [FS_W-1:0] code,
  output logic            rsvd,
  output logic            pair_cpu,
  output logic            test_mode,
  output logic            done
);
  logic            pg_d_q;
  logic [FS_W-1:0] code_q, code_n;
  logic            rsvd_q, rsvd_n;
  logic            pair_q, pair_n;
  logic            test_q, test_n;
  logic            done_q, done_n;
  logic            rise;
  logic            arm;

  assign rise = pg_s & ~pg_d_q;
  assign arm  = rise & (~done_q | test_q);

  always_comb begin
    code_n = code_q;
    rsvd_n = rsvd_q;
    pair_n = pair_q;
    test_n = test_q;
    done_n = done_q;
    if (arm) begin
      done_n = 1'b1;
      pair_n = dbg_en;
      test_n = tsel;
      if (fsel == FS_RSVD) begin
        rsvd_n = 1'b1;
      end else begin
        rsvd_n = 1'b0;
        code_n = fsel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d_q <= 1'b0;
      code_q <= FS_DEFAULT;
      rsvd_q <= 1'b0;
      pair_q <= 1'b0;
      test_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pg_d_q <= pg_s;
      code_q <= code_n;
      rsvd_q <= rsvd_n;
      pair_q <= pair_n;
      test_q <= test_n;
      done_q <= done_n;
    end
  end

  assign code      = code_q;
  assign rsvd      = rsvd_q;
  assign pair_cpu  = pair_q;
  assign test_mode = test_q;
  assign done      = done_q;
endmodule

// File: rtl/pgs_role.sv
module pgs_role (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic done,
  input  logic test_mode,
  input  logic fs_mid,
  output logic pdn_req,
  output logic tristate,
  output logic refdiv
);
  logic fs_mid_q;
  logic fs_mid_n;

  always_comb begin
    fs_mid_n = fs_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_mid_q <= 1'b0;
    else        fs_mid_q <= fs_mid_n;
  end

  assign pdn_req  = done & ~pg_s;
  assign tristate = test_mode & ~fs_mid_q;
  assign refdiv   = test_mode &  fs_mid_q;
endmodule

// File: rtl/pgs_strap_ctl.sv
module pgs_strap_ctl
  import pgs_pkg::*;
#(
  parameter int PG_SYNC_STAGES  = 2,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fsel_i,
  input  logic            dbg_en_i,
  input  logic            tsel_i,
  input  logic            pg_pin_i,
  output logic [FS_W-1:0] freq_code_o,
  output logic            freq_rsvd_o,
  output logic            pair_cpu_o,
  output logic            test_mode_o,
  output logic            tristate_o,
  output logic            refdiv_o,
  output logic            pdn_req_o
);
  logic rst_core_n;
  logic pg_s;
  logic latch_done;

  pgs_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  pgs_sync #(.STAGES(PG_SYNC_STAGES)) u_pg_sync (
    .clk(clk), .rst_n(rst_core_n), .d(pg_pin_i), .q(pg_s)
  );

  pgs_strap_latch u_latch (
    .clk(clk), .rst_n(rst_core_n), .pg_s(pg_s),
    .fsel(fsel_i), .dbg_en(dbg_en_i), .tsel(tsel_i),
    .code(freq_code_o), .rsvd(freq_rsvd_o), .pair_cpu(pair_cpu_o),
    .test_mode(test_mode_o), .done(latch_done)
  );

  pgs_role u_role (
    .clk(clk), .rst_n(rst_core_n), .pg_s(pg_s), .done(latch_done),
    .test_mode(test_mode_o), .fs_mid(fsel_i[1]),
    .pdn_req(pdn_req_o), .tristate(tristate_o), .refdiv(refdiv_o)
  );
endmodule

// File: rtl/pgs_strap_ctl_chk.sv
module pgs_strap_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] code,
  input logic       rsvd,
  input logic       pair,
  input logic       test,
  input logic       tristate,
  input logic       refdiv,
  input logic       pdn,
  input logic       done
);
  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code != 3'b111);

  assert_pdn_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pdn |-> done);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !test) |=> ($stable(code) && $stable(rsvd) && $stable(pair) && !test));

  assert_test_outs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tristate || refdiv) |-> (test && !(tristate && refdiv)));

  assert_rsvd_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsvd) |-> $stable(code));
endmodule

bind pgs_strap_ctl pgs_strap_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .code(freq_code_o), .rsvd(freq_rsvd_o),
  .pair(pair_cpu_o), .test(test_mode_o), .tristate(tristate_o),
  .refdiv(refdiv_o), .pdn(pdn_req_o), .done(latch_done)
);

// File: tb/pgs_strap_ctl_bench.sv
module pgs_strap_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] fsel;
  logic       dbg_en, tsel, pg;
  logic [2:0] code;
  logic       rsvd, pair, test, tristate, refdiv, pdn;

  int n_chk = 0;
  int n_fail = 0;

  logic [2:0] e_code;
  logic       e_rsvd, e_pair, e_test, e_done;

  always #2 clk = ~clk;

  pgs_strap_ctl u_pgs_strap_ctl (
    .clk(clk), .rst_n(rst_n), .fsel_i(fsel), .dbg_en_i(dbg_en), .tsel_i(tsel),
    .pg_pin_i(pg), .freq_code_o(code), .freq_rsvd_o(rsvd), .pair_cpu_o(pair),
    .test_mode_o(test), .tristate_o(tristate), .refdiv_o(refdiv), .pdn_req_o(pdn)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_tri(input logic t, input logic [2:0] f);
    return t & ~f[1];
  endfunction

  function automatic logic exp_pdn(input logic d, input logic p);
    return d & ~p;
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 code"}, code, e_code);
    chk({tag, " R9 rsvd"}, rsvd, e_rsvd);
    chk({tag, " R3 pair"}, pair, e_pair);
    chk({tag, " R6 test"}, test, e_test);
    chk({tag, " R7 tristate"}, tristate, exp_tri(e_test, fsel));
    chk({tag, " R7 refdiv"}, refdiv, e_test & fsel[1]);
    chk({tag, " R5 pdn"}, pdn, exp_pdn(e_done, pg));
    chk({tag, " R10 legal"}, int'(code == 3'b111), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pg = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    e_code = 3'b101; e_rsvd = 0; e_pair = 0; e_test = 0; e_done = 0;
    wait_cyc(4);
  endtask

  task automatic set_straps(input logic [2:0] f, input logic d, input logic t);
    fsel = f; dbg_en = d; tsel = t;
    wait_cyc(3);
  endtask

  task automatic pg_rise();
    if (!pg) begin
      if (!e_done || e_test) begin
        e_done = 1; e_pair = dbg_en; e_test = tsel;
        if (fsel == 3'b111) e_rsvd = 1;
        else begin e_rsvd = 0; e_code = fsel; end
      end
      pg = 1'b1;
      wait_cyc(4);
    end
  endtask

  task automatic pg_fall();
    pg = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; fsel = 3'b000; dbg_en = 0; tsel = 0; pg = 0;
    wait_cyc(2);
    // R1: reset values, including while strap pins move
    chk("R1 code in reset", code, 3'b101);
    chk("R1 pdn in reset", pdn, 0);
    do_reset();
    set_straps(3'b110, 1, 0);
    check_all("R1 after reset");
    // R2 R3: first capture, 400 MHz, pair as CPU clock
    pg_rise();
    check_all("R2 first capture");
    chk("R2 code 110", code, 3'b110);
    chk("R3 pair cpu", pair, 1);
    // R4: strap changes and new edges ignored
    set_straps(3'b001, 0, 1);
    pg_fall();
    chk("R5 pdn high", pdn, 1);
    pg_rise();
    chk("R4 code kept", code, 3'b110);
    chk("R4 test still off", test, 0);
    check_all("R4 ignore");
    // R9: reserved at first capture keeps default
    do_reset();
    set_straps(3'b111, 0, 1);
    pg_rise();
    chk("R9 rsvd flag", rsvd, 1);
    chk("R9 default kept", code, 3'b101);
    chk("R6 test on", test, 1);
    // R7: live test output select
    set_straps(3'b111, 0, 1);
    chk("R7 refdiv", refdiv, 1);
    set_straps(3'b101, 0, 1);
    chk("R7 tristate", tristate, 1);
    // R8: re-capture in test mode with pdn release in same cycle
    pg_fall();
    chk("R5 pdn in test", pdn, 1);
    set_straps(3'b011, 1, 1);
    pg_rise();
    chk("R8 recapture code", code, 3'b011);
    chk("R9 rsvd cleared", rsvd, 0);
    chk("R5 pdn released", pdn, 0);
    // R8: leave test mode
    pg_fall();
    set_straps(3'b000, 0, 0);
    pg_rise();
    chk("R8 test exit", test, 0);
    chk("R8 code 000", code, 3'b000);
    // random
    for (int it = 0; it < 400; it++) begin
      int a;
      a = $urandom_range(0, 9);
      if (a == 0) do_reset();
      else if (a < 4) set_straps(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                                 1'($urandom_range(0, 3) != 0));
      else if (a < 7) pg_rise();
      else pg_fall();
      check_all("rand");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule